// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests from a nonmaskable input, eight external latched inputs and four on-chip peripherals (timer 1, timer 2, UART, serial-bus controller). Each request carries a programmable 3-bit priority level. The highest level among the enabled pending requests is presented to the processor as an encoded request. When the processor acknowledges a level, the block returns an 8-bit vector that names the winning source, placed inside a block chosen by a software-written vector base.

Sources of equal level are ordered by a fixed chain. The interlock keeps every request, including the nonmaskable one, away from the processor until software has written the vector base once after reset. Software programs levels and clears latched inputs through a small register bus with eight byte addresses. Writes take effect on the clock edge. Reads are combinational from the address.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, ipl_o is 0, vec_vld_o is 0, the vector base reads 0x00, all levels read 0, and the pending register (address 7) reads 0x00.
- R2: Until the first write to address 0, ipl_o stays 0 and every acknowledge returns the spurious vector, even while sources are pending.
- R3: A rising edge on nmi_i makes that source pending at fixed level 7 whatever is programmed. Its pending state clears when an acknowledge is won by it.
- R4: A rising edge on ext_irq_i[k] passes a two-flop synchronizer and sets pending bit k (channel k+1). The bit stays set until cleared by software, is not cleared by acknowledge, and is readable at address 7 bit k.
- R5: Writing address 7 clears exactly the pending bits written as 1 and leaves the others unchanged.
- R6: A level of 0 disables a source. ipl_o is the maximum level among enabled pending sources and appears one cycle after that state changes.
- R7: The vector is {base[7:4], index}, where base is the byte at address 0. The indices are 0 for the nonmaskable input, 1 to 8 for channels 1 to 8, 9 and 10 for timers 1 and 2, 11 for the UART and 12 for the serial bus.
- R8: When several enabled pending sources hold the acknowledged level, the lowest index wins (nonmaskable, channels 1..8, timer 1, timer 2, UART, serial bus).
- R9: An acknowledge for a level that no enabled pending source holds, including level 0, returns 0x18.
- R10: Levels live at addresses 1 to 4 (channels 2a+1 and 2a+2 at address a+1, in bits [2:0] and [6:4]) and at addresses 5 to 6 (timer 1 and timer 2 at address 5; UART and serial bus at address 6, in the same bit fields). per_irq_i bits 0..3 are timer 1, timer 2, UART and serial bus. These are level requests.
- R11: A one-cycle iack_i with iack_lvl_i yields vec_vld_o high for exactly the following cycle, with vector_o valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| nmi_i | input | 1 | Nonmaskable request, asynchronous, edge |
| ext_irq_i | input | 8 | External latched requests, asynchronous, edge |
| per_irq_i | input | 4 | Peripheral level requests |
| ipl_o | output | 3 | Encoded request level to processor |
| iack_i | input | 1 | Acknowledge strobe |
| iack_lvl_i | input | 3 | Level being acknowledged |
| vec_vld_o | output | 1 | Vector valid |
| vector_o | output | 8 | Returned vector |

## Verification
The hardest state to reach is a tie that is resolved deep in the chain. This needs several sources of one level pending together, with the higher-ordered ones removed one at a time by clears, so that later entries such as the UART and the serial bus can win. Directed sequences build these ties by programming every level equal and then peeling winners off. Random rounds then mix levels, edges, clears and nonmaskable pulses against a bench model of pending state. The locked window is covered by raising edges before the first base write and showing that they surface only afterwards.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned LVL_W      = 3;
  localparam int unsigned ADDR_W     = 3;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned IDX_W      = 4;
  localparam int unsigned ADDR_BASE  = 0;
  localparam int unsigned ADDR_EXT   = 1;
  localparam int unsigned ADDR_CLR   = 7;
  localparam logic [DATA_W-1:0] SPURIOUS_VEC = 8'h18;
  localparam logic [LVL_W-1:0]  NMI_LVL      = 3'd7;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/vic_sync_edge.sv
module vic_sync_edge #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= stg_q[STAGES-1];
  end

  assign rise_o = stg_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/vic_regfile.sv
module vic_regfile
  import vic_pkg::*;
#(
  parameter int unsigned NUM_EXT = 8,
  parameter int unsigned NUM_PER = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [DATA_W-1:0]           rdata_o,
  input  logic [NUM_EXT-1:0]          ext_rise_i,
  output logic [DATA_W-1:0]           base_o,
  output logic                        unlocked_o,
  output logic [NUM_EXT-1:0][LVL_W-1:0] ext_lvl_o,
  output logic [NUM_PER-1:0][LVL_W-1:0] per_lvl_o,
  output logic [NUM_EXT-1:0]          ext_pend_o
);
  localparam int unsigned ADDR_PER = ADDR_EXT + (NUM_EXT + 1) / 2;

  logic clr_hit;
  assign clr_hit = we_i && (addr_i == ADDR_W'(ADDR_CLR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o     <= '0;
      unlocked_o <= 1'b0;
    end else if (we_i && addr_i == ADDR_W'(ADDR_BASE)) begin
      base_o     <= wdata_i;
      unlocked_o <= 1'b1;
    end
  end

  for (genvar c = 0; c < NUM_EXT; c++) begin : g_ext_lvl
    localparam logic [ADDR_W-1:0] A = ADDR_W'(ADDR_EXT + c / 2);
    localparam int unsigned       B = (c % 2) * 4;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 ext_lvl_o[c] <= '0;
      else if (we_i && addr_i == A) ext_lvl_o[c] <= wdata_i[B +: LVL_W];
    end
  end

  for (genvar p = 0; p < NUM_PER; p++) begin : g_per_lvl
    localparam logic [ADDR_W-1:0] A = ADDR_W'(ADDR_PER + p / 2);
    localparam int unsigned       B = (p % 2) * 4;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 per_lvl_o[p] <= '0;
      else if (we_i && addr_i == A) per_lvl_o[p] <= wdata_i[B +: LVL_W];
    end
  end

  // a new edge wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ext_pend_o <= '0;
    else if (clr_hit) ext_pend_o <= (ext_pend_o & ~wdata_i[NUM_EXT-1:0]) | ext_rise_i;
    else              ext_pend_o <= ext_pend_o | ext_rise_i;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADDR_BASE)) rdata_o = base_o;
    if (addr_i == ADDR_W'(ADDR_CLR))  rdata_o[NUM_EXT-1:0] = ext_pend_o;
    for (int c = 0; c < int'(NUM_EXT); c++) begin
      if (addr_i == ADDR_W'(int'(ADDR_EXT) + c / 2))
        rdata_o[(c % 2) * 4 +: LVL_W] = ext_lvl_o[c];
    end
    for (int p = 0; p < int'(NUM_PER); p++) begin
      if (addr_i == ADDR_W'(int'(ADDR_PER) + p / 2))
        rdata_o[(p % 2) * 4 +: LVL_W] = per_lvl_o[p];
    end
  end
endmodule

// File: rtl/vic_resolve.sv
module vic_resolve
  import vic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 13
) (
  input  logic                          unlocked_i,
  input  logic [NUM_SRC-1:0]            pend_i,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0]              ack_lvl_i,
  output logic [LVL_W-1:0]              max_lvl_o,
  output logic                          hit_o,
  output logic [IDX_W-1:0]              win_idx_o
);
  logic [NUM_SRC-1:0] en;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_en
    assign en[i] = unlocked_i && pend_i[i] && (lvl_i[i] != '0);
  end

  // descending scan: last match is the lowest index
  always_comb begin
    max_lvl_o = '0;
    hit_o     = 1'b0;
    win_idx_o = '0;
    for (int i = int'(NUM_SRC) - 1; i >= 0; i--) begin
      if (en[i]) begin
        if (lvl_i[i] > max_lvl_o) max_lvl_o = lvl_i[i];
        if (lvl_i[i] == ack_lvl_i) begin
          hit_o     = 1'b1;
          win_idx_o = IDX_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import vic_pkg::*;
#(
  parameter int unsigned NUM_EXT     = 8,
  parameter int unsigned NUM_PER     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         reg_we_i,
  input  logic [2:0]   reg_addr_i,
  input  logic [7:0]   reg_wdata_i,
  output logic [7:0]   reg_rdata_o,
  input  logic         nmi_i,
  input  logic [7:0]   ext_irq_i,
  input  logic [3:0]   per_irq_i,
  output logic [2:0]   ipl_o,
  input  logic         iack_i,
  input  logic [2:0]   iack_lvl_i,
  output logic         vec_vld_o,
  output logic [7:0]   vector_o
);
  localparam int unsigned NUM_SRC = 1 + NUM_EXT + NUM_PER;

  logic [NUM_EXT-1:0]              ext_rise, ext_pend;
  logic                            nmi_rise, nmi_pend_q;
  logic [DATA_W-1:0]               base;
  logic                            unlocked_q;
  logic [NUM_EXT-1:0][LVL_W-1:0]   ext_lvl;
  logic [NUM_PER-1:0][LVL_W-1:0]   per_lvl;
  logic [NUM_SRC-1:0]              src_pend;
  logic [NUM_SRC-1:0][LVL_W-1:0]   src_lvl;
  logic [LVL_W-1:0]                max_lvl;
  logic                            hit;
  logic [IDX_W-1:0]                win_idx;
  logic [LVL_W-1:0]                ipl_q;
  logic                            vld_q;
  logic [DATA_W-1:0]               vec_q;

  vic_sync_edge #(.WIDTH(NUM_EXT), .STAGES(SYNC_STAGES)) u_ext_sync (
    .clk_i, .rst_ni, .async_i(ext_irq_i), .rise_o(ext_rise)
  );

  vic_sync_edge #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_nmi_sync (
    .clk_i, .rst_ni, .async_i(nmi_i), .rise_o(nmi_rise)
  );

  vic_regfile #(.NUM_EXT(NUM_EXT), .NUM_PER(NUM_PER)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .ext_rise_i(ext_rise), .base_o(base), .unlocked_o(unlocked_q),
    .ext_lvl_o(ext_lvl), .per_lvl_o(per_lvl), .ext_pend_o(ext_pend)
  );

  assign src_pend = {per_irq_i, ext_pend, nmi_pend_q};
  assign src_lvl  = {per_lvl, ext_lvl, NMI_LVL};

  vic_resolve #(.NUM_SRC(NUM_SRC)) u_res (
    .unlocked_i(unlocked_q), .pend_i(src_pend), .lvl_i(src_lvl),
    .ack_lvl_i(iack_lvl_i), .max_lvl_o(max_lvl), .hit_o(hit), .win_idx_o(win_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                nmi_pend_q <= 1'b0;
    else if (nmi_rise)                          nmi_pend_q <= 1'b1;
    else if (iack_i && hit && win_idx == '0)    nmi_pend_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ipl_q <= '0;
      vld_q <= 1'b0;
      vec_q <= '0;
    end else begin
      ipl_q <= max_lvl;
      vld_q <= iack_i;
      if (iack_i) vec_q <= hit ? {base[7:4], win_idx} : SPURIOUS_VEC;
    end
  end

  assign ipl_o     = ipl_q;
  assign vec_vld_o = vld_q;
  assign vector_o  = vec_q;
endmodule

// File: rtl/vic_checker.sv
module vic_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_we_i,
  input logic [2:0] reg_addr_i,
  input logic       iack_i,
  input logic [2:0] ipl_o,
  input logic       vec_vld_o,
  input logic [7:0] vector_o,
  input logic       unlocked,
  input logic       nmi_pend,
  input logic [7:0] ext_pend
);
  p_locked_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked |-> ipl_o == 3'd0);

  p_locked_spur_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_vld_o && !$past(unlocked) |-> vector_o == 8'h18);

  p_nmi_top_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlocked && nmi_pend |=> ipl_o == 3'd7);

  p_ack_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iack_i |=> vec_vld_o);

  p_ack_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iack_i |=> !vec_vld_o);

  p_pend_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i == 3'd7) |=> (($past(ext_pend) & ~ext_pend) == 8'h00));
endmodule

bind prio_irq_ctrl vic_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .iack_i(iack_i), .ipl_o(ipl_o), .vec_vld_o(vec_vld_o), .vector_o(vector_o),
  .unlocked(unlocked_q), .nmi_pend(nmi_pend_q), .ext_pend(ext_pend)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       nmi = 1'b0;
  logic [7:0] ext = '0;
  logic [3:0] per = '0;
  logic [2:0] ipl;
  logic       iack = 1'b0;
  logic [2:0] iack_lvl = '0;
  logic       vld;
  logic [7:0] vec;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] m_base = '0;
  bit         m_unl = 0, m_nmi = 0;
  logic [7:0] m_pend = '0;
  logic [3:0] m_per = '0;
  logic [2:0] m_lvl [13];

  always #4 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .nmi_i(nmi), .ext_irq_i(ext), .per_irq_i(per), .ipl_o(ipl),
    .iack_i(iack), .iack_lvl_i(iack_lvl), .vec_vld_o(vld), .vector_o(vec)
  );

  function automatic bit m_src(input int i);
    if (i == 0) return m_nmi;
    if (i <= 8) return m_pend[i-1];
    return m_per[i-9];
  endfunction

  function automatic logic [2:0] exp_ipl();
    logic [2:0] mx = '0;
    if (!m_unl) return '0;
    for (int i = 0; i < 13; i++)
      if (m_src(i) && m_lvl[i] != 0 && m_lvl[i] > mx) mx = m_lvl[i];
    return mx;
  endfunction

  function automatic int exp_win(input logic [2:0] l);
    if (!m_unl || l == 0) return -1;
    for (int i = 0; i < 13; i++)
      if (m_src(i) && m_lvl[i] == l) return i;
    return -1;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    case (a)
      3'd0: begin m_base = d; m_unl = 1; end
      3'd1, 3'd2, 3'd3, 3'd4: begin
        m_lvl[2*(a-1)+1] = d[2:0]; m_lvl[2*(a-1)+2] = d[6:4];
      end
      3'd5: begin m_lvl[9] = d[2:0]; m_lvl[10] = d[6:4]; end
      3'd6: begin m_lvl[11] = d[2:0]; m_lvl[12] = d[6:4]; end
      default: m_pend = m_pend & ~d;
    endcase
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse_ext(input logic [7:0] m);
    @(negedge clk);
    ext = m;
    repeat (4) @(negedge clk);
    ext = '0;
    repeat (4) @(negedge clk);
    m_pend = m_pend | m;
  endtask

  task automatic pulse_nmi();
    @(negedge clk);
    nmi = 1'b1;
    repeat (4) @(negedge clk);
    nmi = 1'b0;
    repeat (4) @(negedge clk);
    m_nmi = 1;
  endtask

  task automatic set_per(input logic [3:0] p);
    @(negedge clk);
    per = p; m_per = p;
  endtask

  task automatic chk_ipl(input string tag);
    repeat (2) @(negedge clk);
    check(tag, {5'd0, ipl}, {5'd0, exp_ipl()});
  endtask

  task automatic ack(input string tag, input logic [2:0] l);
    int w;
    logic [7:0] e;
    w = exp_win(l);
    e = (w < 0) ? 8'h18 : {m_base[7:4], 4'(w)};
    @(negedge clk);
    iack = 1'b1; iack_lvl = l;
    @(negedge clk);
    iack = 1'b0;
    check({tag, " vld R11"}, {7'd0, vld}, 8'd1);
    check(tag, vec, e);
    if (w == 0) m_nmi = 0;
    @(negedge clk);
    check({tag, " vld drop R11"}, {7'd0, vld}, 8'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 13; i++) m_lvl[i] = '0;
    m_lvl[0] = 3'd7;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 ipl", {5'd0, ipl}, 8'd0);
    check("R1 vld", {7'd0, vld}, 8'd0);
    rd(3'd0, d); check("R1 base", d, 8'h00);
    rd(3'd7, d); check("R1 pend", d, 8'h00);
    rd(3'd3, d); check("R1 level", d, 8'h00);

    // R2 interlock; level writes do not unlock
    wr(3'd1, 8'h05);
    rd(3'd1, d); check("R10 level readback", d, 8'h05);
    pulse_ext(8'h01);
    pulse_nmi();
    chk_ipl("R2 locked ipl");
    ack("R2 locked ack", 3'd7);
    rd(3'd7, d); check("R4 latched while locked", d, 8'h01);

    // unlock
    wr(3'd0, 8'hA5);
    chk_ipl("R3 nmi level 7");
    ack("R3 R7 nmi vector", 3'd7);
    chk_ipl("R3 nmi cleared R6");
    ack("R7 channel 1 vector", 3'd5);
    rd(3'd7, d); check("R4 not cleared by ack", d, 8'h01);

    // R8 ties
    wr(3'd1, 8'h33); wr(3'd2, 8'h33); wr(3'd3, 8'h33); wr(3'd4, 8'h33);
    wr(3'd5, 8'h33); wr(3'd6, 8'h33);
    wr(3'd7, 8'hFF);
    pulse_ext(8'h14);
    set_per(4'b0001);
    chk_ipl("R8 tie ipl");
    ack("R8 tie ch3", 3'd3);
    wr(3'd7, 8'h04);
    ack("R8 tie ch5", 3'd3);
    wr(3'd7, 8'h10);
    ack("R8 tie timer1", 3'd3);
    set_per(4'b1000);
    ack("R8 serial bus", 3'd3);
    set_per(4'b1100);
    ack("R8 uart over serial", 3'd3);
    set_per(4'b0000);

    // R6 disable by level 0
    wr(3'd3, 8'h30);
    pulse_ext(8'h10);
    chk_ipl("R6 disabled ipl");
    ack("R9 disabled ack", 3'd3);
    ack("R9 level 0 ack", 3'd0);

    // R5 selective clear
    pulse_ext(8'hFF);
    wr(3'd7, 8'h0F);
    rd(3'd7, d); check("R5 partial clear", d, 8'hF0);
    wr(3'd7, 8'hFF);

    // random rounds
    for (int it = 0; it < 60; it++) begin
      for (int a = 1; a <= 6; a++) wr(3'(a), 8'($urandom) & 8'h77);
      if ($urandom_range(0, 3) == 0) pulse_nmi();
      pulse_ext(8'($urandom));
      set_per(4'($urandom));
      chk_ipl("R6 random ipl");
      if (exp_ipl() != 0) ack("R8 random top ack", exp_ipl());
      ack("R7 random ack", 3'($urandom));
      wr(3'd7, 8'($urandom));
      rd(3'd7, d); check("R5 random pend", d, m_pend);
      if ($urandom_range(0, 4) == 0) wr(3'd0, 8'($urandom));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule